// File: doc/BRIEF.md
# Receive Scatter DMA Channel with Frame Status Word

This channel takes frames from a byte stream and stores them in memory buffers. The buffers are described by a ring of descriptors that software owns. Each descriptor gives a buffer address, a byte capacity, a wrap marker and a completion-interrupt request. The descriptor ring is read combinationally through an index port. Stored bytes leave on a simple write port, which carries either one byte or one 32-bit word.

In the first buffer of a frame, the first four bytes are reserved for a status word. Payload starts after them, shifted by a programmable byte offset. A frame longer than its first buffer spills into later descriptors. Once the last byte is stored, the channel writes the status word into the first buffer. The word holds the frame length, an overflow flag and the number of descriptors used.

The channel can run out of posted descriptors in the middle of a frame. A control bit then decides what happens. Either the rest of the frame is discarded and the status word still goes out, or the channel halts and reports an error. A status port shows the channel state, the current descriptor index and an error code.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the state is 0 (disabled), the error code is 0, the current index is 0, `in_ready` is low and no memory write occurs.
- R2: While `rx_en` is low, the channel accepts no byte and issues no write. Raising `rx_en` moves the state to 2 (idle) and clears the error code to 0.
- R3: In the first buffer, payload byte k goes to buffer address + 4 + `frame_ofs` + k. Each later buffer is filled from its own address upward. A buffer holds at most its byte count, and the first buffer's count includes the 4 status bytes and the offset.
- R4: The descriptor at the current index may be used only when that index differs from `last_post`. Otherwise the channel stays idle (state 2) with `in_ready` low.
- R5: The descriptor after index i is 0 when descriptor i has its end-of-table bit set, and i+1 otherwise.
- R6: After the last byte of the frame is stored, one word write (`mem_word`=1) goes to the first buffer's address. Its bits 15:0 hold the total number of frame bytes received, including dropped ones. Bit 23 is the overflow flag. Bits 27:24 hold the number of descriptors used minus one, saturating at 15. All other bits are 0.
- R7: With `ovf_cont` set, a frame that needs a descriptor beyond the posted ones has its remaining bytes accepted and dropped. The status word is then written with bit 23 set, and the channel returns to idle.
- R8: With `ovf_cont` clear, that same case leaves the channel in state 3 (stopped) with error code 2. No status word is written, and `in_ready` stays low until `rx_en` is dropped, which gives state 0.
- R9: A descriptor that cannot hold data is a protocol error: error code 1 and state 3. For the first buffer this means a byte count at most 4 + `frame_ofs`; for a later buffer it means a byte count of 0.
- R10: `irq` is a one-cycle pulse, in the cycle right after the status word write, when the last descriptor used by the frame has its interrupt bit set.
- R11: After a completed frame, the current index points to the descriptor that follows (per R5) the last one used.
- R12: The state field reads 1 (active) from the first accepted byte until the status word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Channel enable |
| frame_ofs | input | OFSW | Payload byte offset after the status word |
| ovf_cont | input | 1 | 1 = drop and continue on overflow, 0 = halt |
| last_post | input | IDXW | First index software has not posted |
| desc_idx | output | IDXW | Descriptor index being read |
| desc_addr | input | AW | Buffer address of the indexed descriptor |
| desc_len | input | BCW | Buffer byte count of the indexed descriptor |
| desc_eot | input | 1 | Indexed descriptor is the last in the ring |
| desc_ioc | input | 1 | Indexed descriptor requests a completion interrupt |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Channel accepts the byte this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the write |
| mem_wdata | output | 32 | Write data (byte in 7:0 or full word) |
| mem_word | output | 1 | 1 = 32-bit status word, 0 = single byte |
| irq | output | 1 | Frame completion interrupt pulse |
| st_state | output | 4 | 0 disabled, 1 active, 2 idle, 3 stopped |
| st_err | output | 4 | 0 none, 1 protocol, 2 overflow |
| st_cur | output | IDXW | Current descriptor index |

## Verification
Some rules are checked by the assertions on every cycle. A disabled or idle channel never accepts a byte and never writes. A stopped channel always shows a nonzero error code and stays silent. The interrupt lasts exactly one cycle and always follows a status word write. Buffer placement, the values in the status word, overflow handling under both policies, protocol errors and ring wrap can only be shown by the bench's frames. The bench compares the whole memory image after each frame with one it builds from the descriptor ring.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int HDR_BYTES = 4;
    localparam int HDR_LEN_W = 16;
    localparam int HDR_CNT_W = 4;

    typedef enum logic [2:0] {
        S_OFF, S_IDLE, S_FILL, S_ADV, S_LOAD, S_DROP, S_HDR, S_HALT
    } rx_state_e;

    localparam logic [3:0] STAT_OFF    = 4'd0;
    localparam logic [3:0] STAT_ACTIVE = 4'd1;
    localparam logic [3:0] STAT_IDLE   = 4'd2;
    localparam logic [3:0] STAT_HALT   = 4'd3;

    localparam logic [3:0] ERR_NONE  = 4'd0;
    localparam logic [3:0] ERR_PROTO = 4'd1;
    localparam logic [3:0] ERR_OVF   = 4'd2;
endpackage

// File: rtl/rxd_ring_step.sv
module rxd_ring_step #(
    parameter int IDXW = 12
) (
    input  logic [IDXW-1:0] cur,
    input  logic            eot,
    input  logic [IDXW-1:0] last_post,
    output logic            cur_avail,
    output logic [IDXW-1:0] nxt,
    output logic            nxt_avail
);
    always_comb begin
        nxt       = eot ? '0 : cur + 1'b1;
        cur_avail = (cur != last_post);
        nxt_avail = (nxt != last_post);
    end
endmodule

// File: rtl/rxd_hdr_pack.sv
module rxd_hdr_pack
    import rxd_pkg::*;
(
    input  logic [HDR_LEN_W-1:0] flen,
    input  logic                 ovf,
    input  logic [HDR_CNT_W-1:0] ndesc,
    output logic [31:0]          word
);
    always_comb begin
        word = '0;
        word[HDR_LEN_W-1:0] = flen;
        word[23]            = ovf;
        word[27:24]         = ndesc;
    end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxd_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 12,
    parameter int BCW  = 13,
    parameter int OFSW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic [OFSW-1:0] frame_ofs,
    input  logic            ovf_cont,
    input  logic [IDXW-1:0] last_post,
    output logic [IDXW-1:0] desc_idx,
    input  logic [AW-1:0]   desc_addr,
    input  logic [BCW-1:0]  desc_len,
    input  logic            desc_eot,
    input  logic            desc_ioc,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    output logic            in_ready,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    output logic            mem_word,
    output logic            irq,
    output logic [3:0]      st_state,
    output logic [3:0]      st_err,
    output logic [IDXW-1:0] st_cur
);
    typedef struct packed {
        rx_state_e            st;
        logic [IDXW-1:0]      cur;
        logic [AW-1:0]        first_addr;
        logic [AW-1:0]        wr_ptr;
        logic [BCW-1:0]       rem;
        logic [HDR_LEN_W-1:0] flen;
        logic [HDR_CNT_W-1:0] ndesc;
        logic                 ovf;
        logic [3:0]           err;
        logic                 irq;
    } chan_t;

    chan_t q, d;

    logic            cur_avail, nxt_avail;
    logic [IDXW-1:0] nxt_idx;
    logic [31:0]     hdr_word;
    logic [BCW-1:0]  first_need;

    rxd_ring_step #(.IDXW(IDXW)) u_step (
        .cur       (q.cur),
        .eot       (desc_eot),
        .last_post (last_post),
        .cur_avail (cur_avail),
        .nxt       (nxt_idx),
        .nxt_avail (nxt_avail)
    );

    rxd_hdr_pack u_hdr (
        .flen  (q.flen),
        .ovf   (q.ovf),
        .ndesc (q.ndesc),
        .word  (hdr_word)
    );

    assign first_need = BCW'(HDR_BYTES) + BCW'(frame_ofs);

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b0;
        mem_addr  = q.wr_ptr;
        mem_wdata = {24'b0, in_data};
        unique case (q.st)
            S_OFF: begin
                if (rx_en) begin
                    d.st  = S_IDLE;
                    d.err = ERR_NONE;
                end
            end
            S_IDLE: begin
                if (!rx_en) begin
                    d.st = S_OFF;
                end else if (in_valid && cur_avail) begin
                    if (desc_len <= first_need) begin
                        d.err = ERR_PROTO;
                        d.st  = S_HALT;
                    end else begin
                        d.first_addr = desc_addr;
                        d.wr_ptr     = desc_addr + AW'(first_need);
                        d.rem        = desc_len - first_need;
                        d.flen       = '0;
                        d.ndesc      = '0;
                        d.ovf        = 1'b0;
                        d.st         = S_FILL;
                    end
                end
            end
            S_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_we   = 1'b1;
                    d.wr_ptr = q.wr_ptr + 1'b1;
                    d.rem    = q.rem - 1'b1;
                    d.flen   = q.flen + 1'b1;
                    if (in_last) d.st = S_HDR;
                    else if (q.rem == BCW'(1)) d.st = S_ADV;
                end
            end
            S_ADV: begin
                if (nxt_avail) begin
                    d.cur   = nxt_idx;
                    d.ndesc = (q.ndesc == '1) ? q.ndesc : q.ndesc + 1'b1;
                    d.st    = S_LOAD;
                end else begin
                    d.ovf = 1'b1;
                    if (ovf_cont) begin
                        d.st = S_DROP;
                    end else begin
                        d.err = ERR_OVF;
                        d.st  = S_HALT;
                    end
                end
            end
            S_LOAD: begin
                if (desc_len == '0) begin
                    d.err = ERR_PROTO;
                    d.st  = S_HALT;
                end else begin
                    d.wr_ptr = desc_addr;
                    d.rem    = desc_len;
                    d.st     = S_FILL;
                end
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.flen = q.flen + 1'b1;
                    if (in_last) d.st = S_HDR;
                end
            end
            S_HDR: begin
                mem_we    = 1'b1;
                mem_word  = 1'b1;
                mem_addr  = q.first_addr;
                mem_wdata = hdr_word;
                d.irq     = desc_ioc;
                d.cur     = nxt_idx;
                d.st      = S_IDLE;
            end
            S_HALT: begin
                if (!rx_en) d.st = S_OFF;
            end
            default: d.st = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_OFF, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            S_OFF:   st_state = STAT_OFF;
            S_IDLE:  st_state = STAT_IDLE;
            S_HALT:  st_state = STAT_HALT;
            default: st_state = STAT_ACTIVE;
        endcase
    end

    assign desc_idx = q.cur;
    assign st_cur   = q.cur;
    assign st_err   = q.err;
    assign irq      = q.irq;
endmodule

// File: rtl/rxd_chk.sv
module rxd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       mem_we,
    input logic       mem_word,
    input logic       irq,
    input logic [3:0] st_state,
    input logic [3:0] st_err
);
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_state == 4'd0 |-> !in_ready && !mem_we); // R2
    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        st_state == 4'd2 |-> !in_ready && !mem_we); // R4
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        st_state == 4'd3 |-> st_err != 4'd0 && !in_ready && !mem_we); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10
    AST_IRQ_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_we && mem_word)); // R10
    AST_WORD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_word |-> st_state == 4'd1); // R12
endmodule

bind rx_ring_dma rxd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .mem_we   (mem_we),
    .mem_word (mem_word),
    .irq      (irq),
    .st_state (st_state),
    .st_err   (st_err)
);

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int MSZ = 512;

    logic        clk = 0, rst_n = 0;
    logic        rx_en = 0, ovf_cont = 0;
    logic [6:0]  frame_ofs = 0;
    logic [11:0] last_post = 0;
    logic [11:0] desc_idx;
    logic [31:0] desc_addr;
    logic [12:0] desc_len;
    logic        desc_eot, desc_ioc;
    logic        in_valid = 0, in_last = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, mem_we, mem_word, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  st_state, st_err;
    logic [11:0] st_cur;

    int  d_addr [NR];
    int  d_len  [NR];
    bit  d_eot  [NR];
    bit  d_ioc  [NR];
    logic [7:0] got_mem [MSZ];
    logic [7:0] exp_mem [MSZ];
    logic [7:0] fb [256];
    int checks = 0, errors = 0, wcnt = 0, irq_cnt = 0, cycles = 0;
    int ring_pos = 0;
    int m_idx, m_nd, m_err;
    bit m_ov, m_halt;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign desc_addr = 32'(d_addr[desc_idx[2:0]]);
    assign desc_len  = 13'(d_len[desc_idx[2:0]]);
    assign desc_eot  = d_eot[desc_idx[2:0]];
    assign desc_ioc  = d_ioc[desc_idx[2:0]];

    rx_ring_dma u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_ofs(frame_ofs),
        .ovf_cont(ovf_cont), .last_post(last_post), .desc_idx(desc_idx),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_eot(desc_eot),
        .desc_ioc(desc_ioc), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_word(mem_word),
        .irq(irq), .st_state(st_state), .st_err(st_err), .st_cur(st_cur)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            wcnt++;
            if (mem_word) begin
                for (int b = 0; b < 4; b++)
                    if (mem_addr + b < MSZ) got_mem[mem_addr + b] = mem_wdata[8*b +: 8];
            end else if (mem_addr < MSZ) begin
                got_mem[mem_addr] = mem_wdata[7:0];
            end
        end
        if (irq) irq_cnt++;
    end

    task automatic ck(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt(input int i);
        return d_eot[i] ? 0 : i + 1;
    endfunction

    // Reference model built from R3, R5, R6, R7, R8, R9.
    task automatic model(input int len, input int ofs, input bit cont, input int lastp);
        int pos, rem, k, nx;
        m_idx = ring_pos; m_nd = 0; m_ov = 0; m_halt = 0; m_err = 0;
        if (d_len[m_idx] <= 4 + ofs) begin
            m_halt = 1; m_err = 1; return;
        end
        pos = d_addr[m_idx] + 4 + ofs;
        rem = d_len[m_idx] - 4 - ofs;
        for (k = 0; k < len; k++) begin
            if (m_ov) continue;
            if (rem == 0) begin
                nx = nxt(m_idx);
                if (nx == lastp) begin
                    m_ov = 1;
                    if (!cont) begin m_halt = 1; m_err = 2; break; end
                    continue;
                end
                m_idx = nx; m_nd++;
                if (d_len[m_idx] == 0) begin m_halt = 1; m_err = 1; break; end
                pos = d_addr[m_idx]; rem = d_len[m_idx];
            end
            exp_mem[pos] = fb[k];
            pos++; rem--;
        end
        if (!m_halt) begin
            logic [31:0] h;
            h = {4'd0, 4'((m_nd > 15) ? 15 : m_nd), m_ov, 7'd0, 16'(len)};
            for (int b = 0; b < 4; b++) exp_mem[d_addr[ring_pos] + b] = h[8*b +: 8];
        end
    endtask

    task automatic send_byte(input logic [7:0] dt, input logic l, output bit ok);
        in_valid = 1; in_data = dt; in_last = l; ok = 0;
        for (int w = 0; w < 60; w++) begin
            @(negedge clk);
            if (in_ready) begin ok = 1; break; end
        end
        if (ok) begin @(posedge clk); #1; end
    endtask

    task automatic run_frame(input string tag, input int len, input int ofs,
                             input bit cont, input int lastp);
        bit ok;
        int mism, irq0;
        logic [31:0] hw;
        frame_ofs = 7'(ofs); ovf_cont = cont; last_post = 12'(lastp);
        for (int a = 0; a < MSZ; a++) begin got_mem[a] = 0; exp_mem[a] = 0; end
        for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
        model(len, ofs, cont, lastp);
        irq0 = irq_cnt;
        for (int k = 0; k < len; k++) begin
            send_byte(fb[k], k == len - 1, ok);
            if (!ok) break;
            if (k == 0) ck({tag, " R12 active after first byte"}, st_state, 1);
        end
        @(negedge clk);
        in_valid = 0; in_last = 0;
        repeat (4) @(negedge clk);
        mism = 0;
        for (int a = 0; a < MSZ; a++) if (got_mem[a] !== exp_mem[a]) mism++;
        ck({tag, " R3 R6 memory image mismatches"}, mism, 0);
        if (!m_halt) begin
            for (int b = 0; b < 4; b++) hw[8*b +: 8] = got_mem[d_addr[ring_pos] + b];
            ck({tag, " R6 header overflow bit"}, hw[23], m_ov);
            ck({tag, " R6 header length"}, hw[15:0], len);
            ck({tag, " R2 R12 idle after frame"}, st_state, 2);
            ck({tag, " R5 R11 next index"}, st_cur, nxt(m_idx));
            ck({tag, " R10 irq pulses"}, irq_cnt - irq0, d_ioc[m_idx]);
            ring_pos = nxt(m_idx);
        end else begin
            ck({tag, " R8 R9 stopped state"}, st_state, 3);
            ck({tag, " R8 R9 error code"}, st_err, m_err);
            ck({tag, " R8 R9 index held"}, st_cur, m_idx);
            ring_pos = m_idx;
        end
    endtask

    task automatic recover();
        @(posedge clk); #1; rx_en = 0;
        repeat (2) @(negedge clk);
        ck("R8 disable leaves stop", st_state, 0);
        @(posedge clk); #1; rx_en = 1;
        repeat (2) @(negedge clk);
        ck("R2 enable clears error", st_err, 0);
        ck("R2 enable gives idle", st_state, 2);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < NR; i++) begin
            d_addr[i] = i * 64; d_len[i] = 20; d_eot[i] = (i == NR - 1); d_ioc[i] = 0;
        end
        repeat (3) @(negedge clk);
        ck("R1 reset state", st_state, 0);
        ck("R1 reset error", st_err, 0);
        ck("R1 reset index", st_cur, 0);
        ck("R1 reset ready", in_ready, 0);
        @(posedge clk); #1; rst_n = 1;

        // R2: input ignored while disabled
        in_valid = 1; in_data = 8'h5a; in_last = 1;
        repeat (6) @(negedge clk);
        ck("R2 disabled no ready", in_ready, 0);
        ck("R2 disabled no write", wcnt, 0);
        @(posedge clk); #1; in_valid = 0; rx_en = 1;
        repeat (2) @(negedge clk);
        ck("R2 enabled idle", st_state, 2);

        // R4: no posted descriptor
        last_post = 12'(ring_pos);
        @(posedge clk); #1; in_valid = 1;
        repeat (6) @(negedge clk);
        ck("R4 waits without descriptor", st_state, 2);
        ck("R4 no write without descriptor", wcnt, 0);
        @(posedge clk); #1; in_valid = 0;

        // Directed: spans three buffers with irq on the last
        d_len[0] = 10; d_len[1] = 8; d_len[2] = 30; d_ioc[2] = 1;
        run_frame("multi", 25, 2, 0, 7);
        d_ioc[2] = 0;

        // Directed R7: overflow continue
        for (int i = 0; i < NR; i++) d_len[i] = 8;
        run_frame("R7 ovf continue", 40, 0, 1, (ring_pos + 2) % NR);

        // Directed R8: overflow halt
        run_frame("R8 ovf halt", 40, 1, 0, (ring_pos + 2) % NR);
        recover();

        // Directed R9: first buffer too small, then zero-length later buffer
        d_len[ring_pos] = 4 + 3;
        run_frame("R9 first too small", 5, 3, 0, (ring_pos + 7) % NR);
        recover();
        d_len[ring_pos] = 8; d_len[(ring_pos + 1) % NR] = 0;
        run_frame("R9 zero length", 20, 0, 0, (ring_pos + 7) % NR);
        recover();

        // Random frames, ring wraps many times (R5)
        for (int f = 0; f < 30; f++) begin
            for (int i = 0; i < NR; i++) begin
                d_len[i] = 8 + int'($urandom_range(0, 40));
                d_ioc[i] = $urandom_range(0, 1) == 1;
            end
            run_frame("random", 1 + int'($urandom_range(0, 90)),
                      int'($urandom_range(0, 3)), 1, (ring_pos + NR - 1) % NR);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule